// File: doc/BRIEF.md
# Datagram IRQ Event Merger

This block sits on the frame path of a fieldbus slave node. It holds a 16-bit register of pending events and a 16-bit event mask. When the frame's IRQ word passes by, the block ANDs the pending events with the mask and ORs the result into the word as it arrived. It then hands the word on one clock later. The merge can only add bits. A bit that an upstream node has already set stays set, because no node further down can tell where it came from.

Pending bits are raised in two ways:
- General event sources send one-cycle set pulses.
- Buffer events come in through a per-buffer enable, so a buffer can raise its bit only while software has enabled it.

Pending bits are cleared by strobes that come from the side effects of register accesses elsewhere in the node, such as a buffer read or a latch-time read. Software reads the mask and the pending events, and writes the mask and the buffer enables, through a byte-wide register port.

Top module: `irq_event_merger`

## Requirements
- R1: After a synchronous reset, the mask, the pending request and every buffer enable read back as zero, and `irq_out_valid` is low.
- R2: The mask is written byte by byte: address 0x0200 holds bits 7:0 and address 0x0201 holds bits 15:8. A read with `reg_rd` high returns the addressed byte on `reg_rdata` at the next clock edge.
- R3: `irq_out_valid` rises exactly one clock after `irq_in_valid`. `irq_out` then equals `irq_in | (request & mask)`, using the request and mask held in the cycle the word was accepted. A set pulse in that same cycle does not reach that word.
- R4: An event whose mask bit is 0 is kept out of `irq_out`. It stays pending and readable at 0x0210 (bits 7:0) and 0x0211 (bits 15:8).
- R5: Every bit that is set in `irq_in` is also set in the matching `irq_out`.
- R6: A pulse on `evt_set[i]` sets request bit i. A strobe on `evt_clr[i]` with no set on that bit clears it.
- R7: If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: Each buffer N (0 to NUM_BUF-1) has a control byte at 0x0804 + 8*N. Bit 0 of that byte is the enable, and it reads back as written. A pulse on `buf_evt[N]` sets request bit 8+N only while that enable is 1.
- R9: Writes to 0x0210 and 0x0211 have no effect, and the request reads back unchanged.
- R10: A read of an address that has no register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Byte address for register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| evt_set | input | 16 | One-cycle set pulses, one per request bit |
| evt_clr | input | 16 | Clear strobes from access side effects |
| buf_evt | input | NUM_BUF | Buffer event pulses, gated by the buffer enables |
| irq_in_valid | input | 1 | Marks the incoming IRQ word |
| irq_in | input | 16 | IRQ word as received |
| irq_out_valid | output | 1 | Marks the outgoing IRQ word |
| irq_out | output | 16 | IRQ word after the merge |

## Verification
The bench builds the block with its default of four buffers. That puts every buffer control address from 0x0804 to 0x081C in range, along with the mapping of buffer events onto request bits 8 to 11. Using buffer 1 reaches an enable that sits off the base address, which exercises the stride decode. Mixed mask patterns also mix masked bits from the low and high bytes in the same merge.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int EVT_W      = 16;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam logic [ADDR_W-1:0] MASK_LO_A = 16'h0200;
  localparam logic [ADDR_W-1:0] MASK_HI_A = 16'h0201;
  localparam logic [ADDR_W-1:0] REQ_LO_A  = 16'h0210;
  localparam logic [ADDR_W-1:0] REQ_HI_A  = 16'h0211;
  localparam logic [ADDR_W-1:0] BUF_BASE_A = 16'h0804;
  localparam int BUF_STRIDE = 8;
  localparam int BUF_BIT0   = 8;
endpackage

// File: rtl/evt_reg_file.sv
module evt_reg_file
  import irq_merge_pkg::*;
#(
  parameter int NUM_BUF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [EVT_W-1:0]  request,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [EVT_W-1:0]  mask,
  output logic [NUM_BUF-1:0] buf_en
);
  logic [NUM_BUF-1:0] buf_hit;
  logic [DATA_W-1:0]  rd_mux;

  for (genvar n = 0; n < NUM_BUF; n++) begin : g_buf
    localparam logic [ADDR_W-1:0] CTRL_A = BUF_BASE_A + ADDR_W'(n * BUF_STRIDE);
    assign buf_hit[n] = (reg_addr == CTRL_A);
    always_ff @(posedge clk) begin
      if (rst) buf_en[n] <= 1'b0;
      else if (reg_wr && buf_hit[n]) buf_en[n] <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == MASK_LO_A) mask[7:0]  <= reg_wdata;
      if (reg_addr == MASK_HI_A) mask[15:8] <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == MASK_LO_A)      rd_mux = mask[7:0];
    else if (reg_addr == MASK_HI_A) rd_mux = mask[15:8];
    else if (reg_addr == REQ_LO_A)  rd_mux = request[7:0];
    else if (reg_addr == REQ_HI_A)  rd_mux = request[15:8];
    else begin
      for (int n = 0; n < NUM_BUF; n++)
        if (buf_hit[n]) rd_mux = {{(DATA_W-1){1'b0}}, buf_en[n]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_addr == MASK_LO_A || reg_addr == MASK_HI_A)) |=> $stable(mask)); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (buf_hit != '0)) |=> $stable(buf_en)); // R8
endmodule

// File: rtl/evt_pending.sv
module evt_pending
  import irq_merge_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set_eff,
  input  logic [EVT_W-1:0] evt_clr,
  output logic [EVT_W-1:0] request
);
  always_ff @(posedge clk) begin
    if (rst) request <= '0;
    else     request <= (request & ~evt_clr) | set_eff;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((request & $past(set_eff)) == $past(set_eff))); // R7
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((request & $past(evt_clr) & ~$past(set_eff)) == '0)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set_eff == '0 && evt_clr == '0) |=> $stable(request)); // R9
endmodule

// File: rtl/irq_merge_stage.sv
module irq_merge_stage
  import irq_merge_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_in_valid,
  input  logic [EVT_W-1:0] irq_in,
  input  logic [EVT_W-1:0] request,
  input  logic [EVT_W-1:0] mask,
  output logic             irq_out_valid,
  output logic [EVT_W-1:0] irq_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out_valid <= 1'b0;
      irq_out       <= '0;
    end else begin
      irq_out_valid <= irq_in_valid;
      if (irq_in_valid) irq_out <= irq_in | (request & mask);
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    irq_in_valid |=> irq_out_valid); // R3
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
    !irq_in_valid |=> !irq_out_valid); // R3
  AST_ONLY_ADDS: assert property (@(posedge clk) disable iff (rst)
    irq_in_valid |=> ((irq_out & $past(irq_in)) == $past(irq_in))); // R5
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_in_valid |=> ((irq_out & ~$past(irq_in) & ~$past(mask)) == '0)); // R4
endmodule

// File: rtl/irq_event_merger.sv
module irq_event_merger
  import irq_merge_pkg::*;
#(
  parameter int NUM_BUF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        reg_addr,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  input  logic               reg_rd,
  output logic [7:0]         reg_rdata,
  input  logic [15:0]        evt_set,
  input  logic [15:0]        evt_clr,
  input  logic [NUM_BUF-1:0] buf_evt,
  input  logic               irq_in_valid,
  input  logic [15:0]        irq_in,
  output logic               irq_out_valid,
  output logic [15:0]        irq_out
);
  logic [EVT_W-1:0]   mask;
  logic [EVT_W-1:0]   request;
  logic [EVT_W-1:0]   set_eff;
  logic [NUM_BUF-1:0] buf_en;

  initial assert (NUM_BUF >= 1 && BUF_BIT0 + NUM_BUF <= EVT_W);

  always_comb begin
    set_eff = evt_set;
    for (int n = 0; n < NUM_BUF; n++)
      set_eff[BUF_BIT0+n] = evt_set[BUF_BIT0+n] | (buf_evt[n] & buf_en[n]);
  end

  evt_reg_file #(.NUM_BUF(NUM_BUF)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .request(request),
    .reg_rdata(reg_rdata), .mask(mask), .buf_en(buf_en)
  );

  evt_pending u_pend (
    .clk(clk), .rst(rst), .set_eff(set_eff), .evt_clr(evt_clr),
    .request(request)
  );

  irq_merge_stage u_merge (
    .clk(clk), .rst(rst), .irq_in_valid(irq_in_valid), .irq_in(irq_in),
    .request(request), .mask(mask), .irq_out_valid(irq_out_valid),
    .irq_out(irq_out)
  );
endmodule

// File: tb/irq_event_merger_test.sv
module irq_event_merger_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  // vector: {mask, set, irq_in, expected irq_out}
  localparam logic [63:0] VEC [5] = '{
    {16'h0000, 16'hFFFF, 16'h1234, 16'h1234},
    {16'hFFFF, 16'h00F0, 16'h0000, 16'h00F0},
    {16'h0F0F, 16'h3C3C, 16'h8001, 16'h8C0D},
    {16'hFFFF, 16'h0000, 16'hA5A5, 16'hA5A5},
    {16'h00FF, 16'hFFFF, 16'hFF00, 16'hFFFF}
  };

  logic clk = 0, rst = 1;
  logic [15:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [15:0] evt_set = '0, evt_clr = '0, irq_in = '0, irq_out;
  logic [NB-1:0] buf_evt = '0;
  logic irq_in_valid = 0, irq_out_valid;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [7:0] rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_event_merger #(.NUM_BUF(NB)) uut (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1;
    @(negedge clk); d = reg_rdata; reg_rd = 0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    evt_set = s; evt_clr = c;
    @(negedge clk); evt_set = '0; evt_clr = '0;
  endtask

  task automatic frame(input string tag, input logic [15:0] w, input logic [15:0] exp);
    irq_in = w; irq_in_valid = 1;
    @(negedge clk); irq_in_valid = 0;
    check({tag, " valid"}, {15'd0, irq_out_valid}, 16'd1);
    check(tag, irq_out, exp);
    @(negedge clk);
    check({tag, " valid drop"}, {15'd0, irq_out_valid}, 16'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out valid in reset", {15'd0, irq_out_valid}, 16'd0);
    rst = 0;
    @(negedge clk);
    rd(16'h0200, rb); check("R1 mask lo", {8'd0, rb}, 16'h0000);
    rd(16'h0201, rb); check("R1 mask hi", {8'd0, rb}, 16'h0000);
    rd(16'h0210, rb); check("R1 req lo", {8'd0, rb}, 16'h0000);
    rd(16'h0211, rb); check("R1 req hi", {8'd0, rb}, 16'h0000);
    rd(16'h0804, rb); check("R1 buf0 en", {8'd0, rb}, 16'h0000);
    frame("R1 pass-through", 16'h5A5A, 16'h5A5A);

    // vector table: mask, set, merge (R3 R4 R5 R6)
    foreach (VEC[i]) begin
      wr(16'h0200, VEC[i][55:48]);
      wr(16'h0201, VEC[i][63:56]);
      rd(16'h0200, rb); check("R2 mask lo readback", {8'd0, rb}, {8'd0, VEC[i][55:48]});
      rd(16'h0201, rb); check("R2 mask hi readback", {8'd0, rb}, {8'd0, VEC[i][63:56]});
      pulse(16'h0000, 16'hFFFF);
      pulse(VEC[i][47:32], 16'h0000);
      frame("R3 R5 merge vector", VEC[i][31:16], VEC[i][15:0]);
      rd(16'h0210, rb); check("R4 R6 pending lo", {8'd0, rb}, {8'd0, VEC[i][39:32]});
      rd(16'h0211, rb); check("R4 R6 pending hi", {8'd0, rb}, {8'd0, VEC[i][47:40]});
    end

    // R3: set in accept cycle not seen by that word
    wr(16'h0200, 8'hFF); wr(16'h0201, 8'hFF);
    pulse(16'h0000, 16'hFFFF);
    irq_in = 16'h0100; irq_in_valid = 1; evt_set = 16'h0001;
    @(negedge clk); irq_in_valid = 0; evt_set = '0;
    check("R3 same-cycle set excluded", irq_out, 16'h0100);
    @(negedge clk);
    frame("R3 next word sees set", 16'h0100, 16'h0101);

    // R6 clear only, R7 set+clear same bit
    pulse(16'h0008, 16'h0000);
    pulse(16'h0008, 16'h0008);
    rd(16'h0210, rb); check("R7 set wins over clear", {8'd0, rb}, 16'h0009);
    pulse(16'h0000, 16'h0008);
    rd(16'h0210, rb); check("R6 clear strobe", {8'd0, rb}, 16'h0001);

    // R9 writes to request ignored
    wr(16'h0210, 8'hFE); wr(16'h0211, 8'hFF);
    rd(16'h0210, rb); check("R9 req lo unchanged", {8'd0, rb}, 16'h0001);
    rd(16'h0211, rb); check("R9 req hi unchanged", {8'd0, rb}, 16'h0000);

    // R8 buffer enable gating (buffer 1 -> bit 9, ctrl 0x080C)
    buf_evt = 4'b0010; @(negedge clk); buf_evt = '0;
    rd(16'h0211, rb); check("R8 disabled buffer ignored", {8'd0, rb}, 16'h0000);
    wr(16'h080C, 8'h01);
    rd(16'h080C, rb); check("R8 enable readback", {8'd0, rb}, 16'h0001);
    rd(16'h0804, rb); check("R8 other buffer untouched", {8'd0, rb}, 16'h0000);
    buf_evt = 4'b0011; @(negedge clk); buf_evt = '0;
    rd(16'h0211, rb); check("R8 enabled buffer sets bit 9", {8'd0, rb}, 16'h0002);

    // R10 unmapped read
    rd(16'h0300, rb); check("R10 unmapped reads zero", {8'd0, rb}, 16'h0000);
    rd(16'h0808, rb); check("R10 between buffers zero", {8'd0, rb}, 16'h0000);

    finish_run();
  end
endmodule